// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a software-serviced watchdog that counts down in coarse ticks. Software programs a timeout value, then services the timer by writing to a reload location, which copies the timeout value into a down-counter. A tick-enable input, pulsed once per tick period (0.6 s in the target system, so S seconds is programmed as S*10/6 ticks), advances the counter. When it runs out, the block flags a first expiry in a status register and reloads itself from the timeout value. If it runs out again while that flag is still set, it marks a second expiry. Unless an external no-reboot input is high, it also raises a one-cycle system-action request.

Registers are reached through a simple 32-bit word bus with byte enables. Reads are combinational from the word index, and writes take effect at the next clock edge. Besides the reload, timeout and two status registers, the block holds two control registers, a pair of mailbox bytes, two message bytes, a count byte and a software interrupt byte. A write to either mailbox byte sets its own status bit and emits a pulse. A halt bit in the first control register freezes the counter.

Top module: `wdog_dual_stage`

## Requirements
- R1: After reset, every word reads zero except word 2, which reads 0x0008_0000 (second control register 0x0008), and word 4, which reads 0x0004_0003 (timeout value 4, software IRQ byte 0x03).
- R2: A write with either byte enable 0 or 1 to word 0 loads the counter with the timeout value. This takes priority over a tick in the same cycle. The live count is read at word 0 bits 9:0.
- R3: Each tick with the halt bit clear decrements a nonzero count by one. Loading N, the count reads 1 after N-1 ticks. On the Nth tick the counter expires and reloads from the timeout value. A count of zero does not move.
- R4: An expiry sets status-1 bit 3 (word 1 bit 3) and produces a one-cycle pulse on expire_pulse.
- R5: Status-1 bits 1, 2 and 3 clear when written with 1 through word 1 byte 0. A hardware set in the same cycle wins over the clear.
- R6: An expiry that occurs while status-1 bit 3 is already set sets status-2 bit 1 (word 1 bit 17).
- R7: Such a second expiry with no_reboot low also sets status-2 bit 2 (word 1 bit 18) and pulses second_req for one cycle. With no_reboot high, neither happens.
- R8: Writing 1 to status-2 bit 1 or bit 2 (word 1 byte 2) clears that bit alone.
- R9: A write to the mailbox-in byte (word 0 bits 23:16) sets status-1 bit 1. A write to the mailbox-out byte (bits 31:24) sets status-1 bit 2. Each byte keeps its written value, and each such write pulses mbox_pulse.
- R10: While control-1 bit 11 (word 2 bit 11) is set, ticks leave the count unchanged.
- R11: The timeout value is 10 bits (word 4 bits 25:16). Writing 0xFFFF stores 0x3FF, and a reload then counts down from 1023.
- R12: The message bytes (word 3 bits 7:0 and 15:8), the count byte (word 3 bits 23:16) and both control registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per watchdog tick |
| no_reboot | input | 1 | Suppresses the second-expiry action request when high |
| bus_word | input | 3 | Word index of the access |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word |
| expire_pulse | output | 1 | One-cycle pulse on each expiry |
| second_req | output | 1 | One-cycle system-action request on a second expiry |
| mbox_pulse | output | 1 | One-cycle pulse on a mailbox byte write |

## Verification
The bench walks the count to exactly one tick before expiry, then one tick past it. A design that is off by one would flag the timeout early or late, or fail to reload to the programmed value. It runs back-to-back expiries with no_reboot high and then low, and clears each status-2 bit separately. A design that ignored the gate or cleared bits together would show a wrong action-request count or a stale bit. It also collides a tick with a reload, and an expiry with a status clear. A design with the wrong priority in either case would lose the reload or drop the timeout flag. Finally it checks a frozen count under halt, and the masked maximum timeout of 1023 ticks.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int BUS_W   = 32;
    localparam int NBYTES  = BUS_W / 8;
    localparam int WORD_AW = 3;

    localparam logic [WORD_AW-1:0] W_RELOAD  = 3'd0;
    localparam logic [WORD_AW-1:0] W_STATUS  = 3'd1;
    localparam logic [WORD_AW-1:0] W_CTRL    = 3'd2;
    localparam logic [WORD_AW-1:0] W_MSG     = 3'd3;
    localparam logic [WORD_AW-1:0] W_TIMEOUT = 3'd4;

    localparam int S1_SWSMI   = 1;
    localparam int S1_MBOXINT = 2;
    localparam int S1_EXPIRED = 3;
    localparam int S2_SECOND  = 1;
    localparam int S2_BOOT    = 2;
    localparam int CTRL1_HALT = 11;

    localparam logic [15:0] S1_IMPL   = 16'h000E;
    localparam logic [15:0] S2_IMPL   = 16'h0006;
    localparam logic [15:0] CTRL2_RST = 16'h0008;
    localparam logic [7:0]  SWIRQ_RST = 8'h03;

    typedef struct packed {
        logic        reload;
        logic        din_wr;
        logic        dout_wr;
        logic [1:0]  ctrl1_be;
        logic [1:0]  ctrl2_be;
        logic [2:0]  msg_be;
        logic        swirq_wr;
        logic [1:0]  tmr_be;
        logic [15:0] s1_w1c;
        logic [15:0] s2_w1c;
    } wr_strobe_t;

    typedef struct packed {
        logic [15:0] count;
        logic [7:0]  din;
        logic [7:0]  dout;
        logic [15:0] sts1;
        logic [15:0] sts2;
        logic [15:0] ctrl1;
        logic [15:0] ctrl2;
        logic [7:0]  msg1;
        logic [7:0]  msg2;
        logic [7:0]  wdcnt;
        logic [7:0]  swirq;
        logic [15:0] tmr;
    } reg_view_t;

    function automatic logic [15:0] merge16(input logic [15:0] old_v,
                                            input logic [15:0] new_v,
                                            input logic [1:0]  be);
        logic [15:0] r;
        r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
        r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
        return r;
    endfunction
endpackage

// File: rtl/wdog_bus_if.sv
`timescale 1ns/1ps
module wdog_bus_if
    import wdog_pkg::*;
(
    input  logic [WORD_AW-1:0] bus_word,
    input  logic               bus_we,
    input  logic [NBYTES-1:0]  bus_be,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  reg_view_t          view,
    output wr_strobe_t         stb,
    output logic [BUS_W-1:0]   bus_rdata
);
    logic [NBYTES-1:0] be_eff;
    logic [BUS_W-1:0]  lane_mask;
    logic [BUS_W-1:0]  wd_m;

    assign be_eff = bus_we ? bus_be : '0;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane_mask[8*g +: 8] = {8{be_eff[g]}};
    end
    assign wd_m = bus_wdata & lane_mask;

    always_comb begin
        stb = '0;
        unique case (bus_word)
            W_RELOAD: begin
                stb.reload  = |be_eff[1:0];
                stb.din_wr  = be_eff[2];
                stb.dout_wr = be_eff[3];
            end
            W_STATUS: begin
                stb.s1_w1c = wd_m[15:0];
                stb.s2_w1c = wd_m[31:16];
            end
            W_CTRL: begin
                stb.ctrl1_be = be_eff[1:0];
                stb.ctrl2_be = be_eff[3:2];
            end
            W_MSG:     stb.msg_be = be_eff[2:0];
            W_TIMEOUT: begin
                stb.swirq_wr = be_eff[0];
                stb.tmr_be   = be_eff[3:2];
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (bus_word)
            W_RELOAD:  bus_rdata = {view.dout, view.din, view.count};
            W_STATUS:  bus_rdata = {view.sts2, view.sts1};
            W_CTRL:    bus_rdata = {view.ctrl2, view.ctrl1};
            W_MSG:     bus_rdata = {8'h00, view.wdcnt, view.msg2, view.msg1};
            W_TIMEOUT: bus_rdata = {view.tmr, 8'h00, view.swirq};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_countdown.sv
`timescale 1ns/1ps
module wdog_countdown #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             halt,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.count = load_val;
        end else if (tick && !halt && (st_q.count != '0)) begin
            if (st_q.count == CNT_W'(1)) begin
                expire     = 1'b1;
                st_d.count = load_val;
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
endmodule

// File: rtl/wdog_status.sv
`timescale 1ns/1ps
module wdog_status
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        expire,
    input  logic        din_wr,
    input  logic        dout_wr,
    input  logic [15:0] s1_w1c,
    input  logic [15:0] s2_w1c,
    input  logic        no_reboot,
    output logic [15:0] sts1,
    output logic [15:0] sts2,
    output logic        expire_pulse,
    output logic        second_req,
    output logic        mbox_pulse
);
    typedef struct packed {
        logic [15:0] sts1;
        logic [15:0] sts2;
        logic        p_exp;
        logic        p_sec;
        logic        p_mbox;
    } sts_state_t;

    sts_state_t st_d, st_q;
    logic       second;
    logic       action;
    logic [15:0] s1_n;
    logic [15:0] s2_n;

    always_comb begin
        st_d   = st_q;
        second = expire && st_q.sts1[S1_EXPIRED];
        action = second && !no_reboot;

        s1_n = st_q.sts1 & ~s1_w1c;
        if (expire)  s1_n[S1_EXPIRED] = 1'b1;
        if (din_wr)  s1_n[S1_SWSMI]   = 1'b1;
        if (dout_wr) s1_n[S1_MBOXINT] = 1'b1;

        s2_n = st_q.sts2 & ~s2_w1c;
        if (second) s2_n[S2_SECOND] = 1'b1;
        if (action) s2_n[S2_BOOT]   = 1'b1;

        st_d.sts1   = s1_n & S1_IMPL;
        st_d.sts2   = s2_n & S2_IMPL;
        st_d.p_exp  = expire;
        st_d.p_sec  = action;
        st_d.p_mbox = din_wr || dout_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts1         = st_q.sts1;
    assign sts2         = st_q.sts2;
    assign expire_pulse = st_q.p_exp;
    assign second_req   = st_q.p_sec;
    assign mbox_pulse   = st_q.p_mbox;
endmodule

// File: rtl/wdog_dual_stage.sv
`timescale 1ns/1ps
module wdog_dual_stage
    import wdog_pkg::*;
#(
    parameter int          TMR_W   = 10,
    parameter logic [15:0] TMR_RST = 16'h0004
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               no_reboot,
    input  logic [WORD_AW-1:0] bus_word,
    input  logic               bus_we,
    input  logic [NBYTES-1:0]  bus_be,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               expire_pulse,
    output logic               second_req,
    output logic               mbox_pulse
);
    typedef struct packed {
        logic [7:0]       din;
        logic [7:0]       dout;
        logic [15:0]      ctrl1;
        logic [15:0]      ctrl2;
        logic [7:0]       msg1;
        logic [7:0]       msg2;
        logic [7:0]       wdcnt;
        logic [7:0]       swirq;
        logic [TMR_W-1:0] tmr;
    } regs_t;

    regs_t       r_d, r_q;
    wr_strobe_t  stb;
    reg_view_t   view;
    logic [15:0] tmr_wide;

    logic             load_w;
    logic             halt_w;
    logic             expire_w;
    logic [TMR_W-1:0] count_w;
    logic [TMR_W-1:0] tmr_w;
    logic [15:0]      sts1_w;
    logic [15:0]      sts2_w;

    wdog_bus_if u_bus (
        .bus_word  (bus_word),
        .bus_we    (bus_we),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .view      (view),
        .stb       (stb),
        .bus_rdata (bus_rdata)
    );

    always_comb begin
        r_d = r_q;
        if (stb.din_wr)    r_d.din   = bus_wdata[23:16];
        if (stb.dout_wr)   r_d.dout  = bus_wdata[31:24];
        r_d.ctrl1 = merge16(r_q.ctrl1, bus_wdata[15:0], stb.ctrl1_be);
        r_d.ctrl2 = merge16(r_q.ctrl2, bus_wdata[31:16], stb.ctrl2_be);
        if (stb.msg_be[0]) r_d.msg1  = bus_wdata[7:0];
        if (stb.msg_be[1]) r_d.msg2  = bus_wdata[15:8];
        if (stb.msg_be[2]) r_d.wdcnt = bus_wdata[23:16];
        if (stb.swirq_wr)  r_d.swirq = bus_wdata[7:0];
        tmr_wide  = merge16(16'(r_q.tmr), bus_wdata[31:16], stb.tmr_be);
        r_d.tmr   = TMR_W'(tmr_wide);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.ctrl2 <= CTRL2_RST;
            r_q.swirq <= SWIRQ_RST;
            r_q.tmr   <= TMR_W'(TMR_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign load_w = stb.reload;
    assign halt_w = r_q.ctrl1[CTRL1_HALT];
    assign tmr_w  = r_q.tmr;

    wdog_countdown #(.CNT_W(TMR_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .load_val (r_q.tmr),
        .tick     (tick_en),
        .halt     (halt_w),
        .count    (count_w),
        .expire   (expire_w)
    );

    wdog_status u_sts (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire       (expire_w),
        .din_wr       (stb.din_wr),
        .dout_wr      (stb.dout_wr),
        .s1_w1c       (stb.s1_w1c),
        .s2_w1c       (stb.s2_w1c),
        .no_reboot    (no_reboot),
        .sts1         (sts1_w),
        .sts2         (sts2_w),
        .expire_pulse (expire_pulse),
        .second_req   (second_req),
        .mbox_pulse   (mbox_pulse)
    );

    always_comb begin
        view       = '0;
        view.count = 16'(count_w);
        view.din   = r_q.din;
        view.dout  = r_q.dout;
        view.sts1  = sts1_w;
        view.sts2  = sts2_w;
        view.ctrl1 = r_q.ctrl1;
        view.ctrl2 = r_q.ctrl2;
        view.msg1  = r_q.msg1;
        view.msg2  = r_q.msg2;
        view.wdcnt = r_q.wdcnt;
        view.swirq = r_q.swirq;
        view.tmr   = 16'(r_q.tmr);
    end
endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk #(
    parameter int TMR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             tick,
    input logic             halt,
    input logic             expire,
    input logic [TMR_W-1:0] count,
    input logic [TMR_W-1:0] tmr,
    input logic [15:0]      sts1,
    input logic [15:0]      sts2,
    input logic             second_req,
    input logic             no_reboot,
    input logic             bus_we,
    input logic [2:0]       bus_word,
    input logic [3:0]       bus_be,
    input logic [31:0]      bus_wdata
);
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(tmr)));

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && !halt && (count > TMR_W'(1))) |=> (count == $past(count) - TMR_W'(1)));

    p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && halt) |=> $stable(count));

    p_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> sts1[3]);

    p_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && sts1[3]) |=> sts2[1]);

    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        second_req |-> (!$past(no_reboot) && sts2[2]));

    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_word == 3'd1 && bus_be[0] && bus_wdata[3] && !expire) |=> !sts1[3]);
endmodule

bind wdog_dual_stage wdog_chk #(.TMR_W(TMR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_w),
    .tick       (tick_en),
    .halt       (halt_w),
    .expire     (expire_w),
    .count      (count_w),
    .tmr        (tmr_w),
    .sts1       (sts1_w),
    .sts2       (sts2_w),
    .second_req (second_req),
    .no_reboot  (no_reboot),
    .bus_we     (bus_we),
    .bus_word   (bus_word),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata)
);

// File: tb/sim_wdog_dual_stage.sv
`timescale 1ns/1ps
module sim_wdog_dual_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        no_reboot = 1'b1;
    logic [2:0]  bus_word = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        expire_pulse, second_req, mbox_pulse;

    wdog_dual_stage u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .no_reboot(no_reboot),
        .bus_word(bus_word), .bus_we(bus_we), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .expire_pulse(expire_pulse), .second_req(second_req), .mbox_pulse(mbox_pulse)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;

    item_t sb[$];
    logic  chk_req = 1'b0;
    int    total = 0;
    int    bad = 0;
    int    n_exp = 0, n_sec = 0, n_mbox = 0;
    bit    done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (expire_pulse) n_exp++;
            if (second_req)   n_sec++;
            if (mbox_pulse)   n_mbox++;
        end
    end

    // monitor: pops expected items and compares with what the design shows
    always @(negedge clk) begin
        if (chk_req && sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                1:       act = 32'(n_exp);
                2:       act = 32'(n_sec);
                3:       act = 32'(n_mbox);
                default: act = bus_rdata & it.mask;
            endcase
            total++;
            if (act !== (it.exp & it.mask)) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp & it.mask);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic drive(input logic tk, input logic we, input logic [2:0] w,
                         input logic [3:0] be, input logic [31:0] d);
        tick_en = tk; bus_we = we; bus_word = w; bus_be = be; bus_wdata = d;
        @(posedge clk); #1;
        tick_en = 1'b0; bus_we = 1'b0; bus_be = '0;
        idle(1);
    endtask

    task automatic wr(input logic [2:0] w, input logic [3:0] be, input logic [31:0] d);
        drive(1'b0, 1'b1, w, be, d);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 3'd0, 4'h0, 32'h0);
    endtask

    task automatic rd(input logic [2:0] w, input logic [31:0] m,
                      input logic [31:0] e, input string tag);
        item_t it;
        it.kind = 0; it.exp = e; it.mask = m; it.tag = tag;
        bus_word = w;
        sb.push_back(it);
        chk_req = 1'b1;
        @(posedge clk); #1;
        chk_req = 1'b0;
    endtask

    task automatic cnt(input int kind, input int e, input string tag);
        item_t it;
        it.kind = kind; it.exp = 32'(e); it.mask = 32'hFFFF_FFFF; it.tag = tag;
        sb.push_back(it);
        chk_req = 1'b1;
        @(posedge clk); #1;
        chk_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [31:0] ALL = 32'hFFFF_FFFF;
    localparam logic [31:0] CNT = 32'h0000_03FF;

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        rd(3'd0, ALL, 32'h0000_0000, "R1 word0");
        rd(3'd1, ALL, 32'h0000_0000, "R1 status");
        rd(3'd2, ALL, 32'h0008_0000, "R1 control");
        rd(3'd3, ALL, 32'h0000_0000, "R1 message");
        rd(3'd4, ALL, 32'h0004_0003, "R1 timeout/swirq");
        rd(3'd5, ALL, 32'h0000_0000, "R1 unused word");

        // R12 plain read/write registers
        wr(3'd3, 4'b0111, 32'hFF33_2211);
        rd(3'd3, ALL, 32'h0033_2211, "R12 message/count bytes");
        wr(3'd2, 4'b1101, 32'h1234_0056);
        rd(3'd2, ALL, 32'h1234_0056, "R12 control regs");
        wr(3'd2, 4'b1111, 32'h0008_0000);

        // R2/R3/R4 basic countdown
        wr(3'd4, 4'b1100, 32'h0006_0000);
        rd(3'd4, ALL, 32'h0006_0003, "R11 timeout write keeps swirq");
        wr(3'd0, 4'b0001, 32'h0);
        rd(3'd0, CNT, 32'd6, "R2 reload loads timeout");
        ticks(5);
        rd(3'd0, CNT, 32'd1, "R3 count after N-1 ticks");
        rd(3'd1, ALL, 32'h0, "R4 no flag before Nth tick");
        ticks(1);
        rd(3'd1, ALL, 32'h0000_0008, "R4 first expiry flag");
        rd(3'd0, CNT, 32'd6, "R3 auto reload after expiry");
        cnt(1, 1, "R4 expire pulse count");

        // R5 clear
        wr(3'd1, 4'b0001, 32'h0000_0008);
        rd(3'd1, ALL, 32'h0, "R5 timeout flag cleared");

        // R6 second expiry with reboot suppressed
        ticks(6);
        rd(3'd1, ALL, 32'h0000_0008, "R6 first expiry again");
        ticks(6);
        rd(3'd1, ALL, 32'h0002_0008, "R6 second expiry flag");
        cnt(2, 0, "R7 no request with no_reboot high");
        cnt(1, 3, "R4 expire pulse count");

        // R8 and R7 with reboot allowed
        wr(3'd1, 4'b0100, 32'h0002_0000);
        rd(3'd1, ALL, 32'h0000_0008, "R8 clear second flag");
        no_reboot = 1'b0;
        ticks(6);
        rd(3'd1, ALL, 32'h0006_0008, "R7 second expiry with boot flag");
        cnt(2, 1, "R7 action request pulse");
        wr(3'd1, 4'b0100, 32'h0004_0000);
        rd(3'd1, ALL, 32'h0002_0008, "R8 clear boot flag alone");
        wr(3'd1, 4'b1111, 32'hFFFF_FFFF);
        rd(3'd1, ALL, 32'h0, "R8 all status cleared");
        no_reboot = 1'b1;

        // R9 mailbox
        wr(3'd0, 4'b0100, 32'h00AB_0000);
        rd(3'd1, ALL, 32'h0000_0002, "R9 mailbox-in status");
        rd(3'd0, ALL, 32'h00AB_0006, "R9 mailbox-in stored, no reload");
        wr(3'd0, 4'b1000, 32'hCD00_0000);
        rd(3'd1, ALL, 32'h0000_0006, "R9 mailbox-out status");
        rd(3'd0, 32'hFFFF_0000, 32'hCDAB_0000, "R9 mailbox-out stored");
        cnt(3, 2, "R9 mailbox pulse count");
        wr(3'd1, 4'b0001, 32'h0000_0006);
        rd(3'd1, ALL, 32'h0, "R5 mailbox bits cleared");

        // R10 halt
        wr(3'd2, 4'b0010, 32'h0000_0800);
        rd(3'd2, ALL, 32'h0008_0800, "R10 halt bit set");
        wr(3'd0, 4'b0001, 32'h0);
        ticks(3);
        rd(3'd0, CNT, 32'd6, "R10 count frozen");
        wr(3'd2, 4'b0010, 32'h0);
        ticks(2);
        rd(3'd0, CNT, 32'd4, "R10 count runs after halt cleared");

        // R2 reload beats tick
        drive(1'b1, 1'b1, 3'd0, 4'b0010, 32'h0);
        rd(3'd0, CNT, 32'd6, "R2 reload wins over tick");

        // R5 set beats clear
        wr(3'd4, 4'b1100, 32'h0002_0000);
        wr(3'd0, 4'b0001, 32'h0);
        ticks(1);
        rd(3'd0, CNT, 32'd1, "R3 one tick left");
        drive(1'b1, 1'b1, 3'd1, 4'b0001, 32'h0000_0008);
        rd(3'd1, ALL, 32'h0000_0008, "R5 expiry wins over clear");
        wr(3'd1, 4'b0001, 32'h0000_0008);
        rd(3'd1, ALL, 32'h0, "R5 cleared afterwards");

        // R11 maximum timeout
        wr(3'd4, 4'b1100, 32'hFFFF_0000);
        rd(3'd4, ALL, 32'h03FF_0003, "R11 timeout masked to 10 bits");
        wr(3'd0, 4'b0001, 32'h0);
        rd(3'd0, CNT, 32'h3FF, "R11 reload to 1023");
        ticks(1022);
        rd(3'd0, CNT, 32'd1, "R11 count 1 after 1022 ticks");
        rd(3'd1, ALL, 32'h0, "R11 no flag yet");
        ticks(1);
        rd(3'd1, ALL, 32'h0000_0008, "R11 expiry on tick 1023");

        idle(3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule